// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive side of an I2C target. It watches the open-drain SCL and SDA lines through a synchroniser and detects Start, repeated Start and Stop. After a Start it shifts in an address byte, or a header byte and a low address byte in 10-bit mode, and compares it with `own_addr`. Once the address matches, each later byte is delivered to a one-byte data register, and an acknowledge is given on the ninth clock when the control register enables it.

Software reaches the block through a small register port with four locations: control, two status words and data. Data leaves the block through that port. The receive-not-empty flag acts as "valid", and a read of the data location acts as "ready". Back-pressure goes out to the bus: if the data register is still full when a further byte completes, the byte is kept in a pending register and SCL is held low until software drains it. SCL is also held low after an address match until software acknowledges the match. Each event flag is cleared only by a fixed pair of register accesses. A read of status 1 arms the pair, and any other access disarms it.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `irq_evt` and `irq_buf` are 0, and all four locations read 0. The locations are: `reg_sel` 0 control, 1 status 1, 2 status 2, 3 data.
- R2: In 7-bit mode, the first byte after a Start is matched only when bits 7:1 equal `own_addr[6:0]` and bit 0 (direction) is 0. A match is acknowledged and sets the address flag (status 1 bit 0). Any other byte is not acknowledged, sets no flag, and the rest of the transfer is ignored.
- R3: While the address flag is set, SCL is held low from the fall of the acknowledge clock onwards. The flag and the hold end only when a status-1 read is followed directly by a status-2 read. Status 2 reads {addressed (bit 1), busy (bit 0)}.
- R4: Data bits are taken on SCL rising edges, most significant bit first. A completed byte goes to the data location and sets the receive-not-empty flag (status 1 bit 3). A data read clears that flag when no overrun is pending.
- R5: After each data byte, SDA is driven low on the ninth clock only if control bit 0 (acknowledge enable) is 1. Otherwise SDA is left released.
- R6: When a byte completes while the data location is still unread, the byte-finished flag (status 1 bit 1) is set and SCL is held low. Only a status-1 read followed directly by a data read clears it. That read returns the older byte, moves the pending byte in, keeps receive-not-empty set and releases SCL. A data read that is not armed has no effect while the flag is set.
- R7: A Stop seen while addressed sets the stop flag (status 1 bit 2). Only a status-1 read followed directly by a control write clears it.
- R8: `irq_evt` equals control bit 1 AND (address OR byte-finished OR stop flag). `irq_buf` equals control bit 1 AND control bit 2 AND receive-not-empty.
- R9: With control bit 3 set (10-bit mode), the first byte must be 11110, `own_addr[9:8]`, 0. It is acknowledged without setting a flag. The next byte must equal `own_addr[7:0]`, and only then is the address flag set. A mismatch of either byte is not acknowledged.
- R10: A repeated Start abandons a partly received byte without delivering it and restarts address matching.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| own_addr | input | 10 | Address this target answers to |
| reg_sel | input | 2 | Register location select |
| reg_rd | input | 1 | Read strobe, side effects on the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_sel`, combinational |
| irq_evt | output | 1 | Event interrupt |
| irq_buf | output | 1 | Buffer interrupt |

## Verification
All 128 seven-bit addresses are swept with the write direction, plus the own address with the read direction, so the acknowledge and flag behaviour is exercised on every neighbour of the match. Data bytes follow an arithmetic sequence that covers all-zero, all-one and alternating patterns, which tells bit-order errors apart from lost bits. The clear sequences are tried both in the correct order and with a stray access placed in between, so a release with no arming shows up as a mismatch at SCL. Ten-bit headers with wrong upper bits, wrong low bytes, the interrupt-enable combinations and a Start inside a byte cover the remaining paths.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int SEL_W  = 2;
  localparam int CTRL_W = 8;

  localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STAT1 = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT2 = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DATA  = 2'd3;

  localparam logic [4:0] HDR_TAG = 5'b11110;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR2,
    LK_DATA,
    LK_ACKSET,
    LK_ACKEND,
    LK_HOLD,
    LK_SKIP
  } link_st_t;

  typedef struct packed {
    logic [3:0] spare;
    logic       ten_bit;
    logic       buf_ie;
    logic       evt_ie;
    logic       ack_en;
  } ctrl_t;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  localparam int SCL_IX = 0;
  localparam int SDA_IX = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now_q;
  logic [LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign now_q[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= now_q;
  end

  assign sda_s     = now_q[SDA_IX];
  assign scl_rise  = now_q[SCL_IX] & ~prev_q[SCL_IX];
  assign scl_fall  = ~now_q[SCL_IX] & prev_q[SCL_IX];
  assign start_det = now_q[SCL_IX] & prev_q[SCL_IX] & ~now_q[SDA_IX] & prev_q[SDA_IX];
  assign stop_det  = now_q[SCL_IX] & prev_q[SCL_IX] & now_q[SDA_IX] & ~prev_q[SDA_IX];
endmodule

// File: rtl/i2c_srx_link.sv
module i2c_srx_link
  import i2c_srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              ack_en,
  input  logic              ten_bit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              hold_req,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              addr_hit,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              stop_hit,
  output logic              bus_busy,
  output logic              addressed
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  link_st_t          st_q;
  link_st_t          after_q;
  logic [BYTE_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_q;
  logic [BYTE_W-1:0] full;
  logic              hdr_ok;
  logic              a7_ok;
  logic              lo_ok;

  assign full   = {sh_q, sda_s};
  assign hdr_ok = (full[7:3] == HDR_TAG) && (full[2:1] == own_addr[9:8]) && !full[0];
  assign a7_ok  = (full[7:1] == own_addr[6:0]) && !full[0];
  assign lo_ok  = (full == own_addr[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LK_IDLE;
      after_q   <= LK_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      ack_q     <= 1'b0;
      sda_oe    <= 1'b0;
      addr_hit  <= 1'b0;
      byte_done <= 1'b0;
      byte_val  <= '0;
      stop_hit  <= 1'b0;
      bus_busy  <= 1'b0;
      addressed <= 1'b0;
    end else begin
      addr_hit  <= 1'b0;
      byte_done <= 1'b0;
      stop_hit  <= 1'b0;
      if (start_det) begin
        st_q      <= LK_ADDR;
        cnt_q     <= '0;
        sda_oe    <= 1'b0;
        bus_busy  <= 1'b1;
        addressed <= 1'b0;
      end else if (stop_det) begin
        st_q      <= LK_IDLE;
        sda_oe    <= 1'b0;
        bus_busy  <= 1'b0;
        addressed <= 1'b0;
        stop_hit  <= addressed;
      end else begin
        case (st_q)
          LK_ADDR, LK_ADDR2, LK_DATA: begin
            if (scl_rise) begin
              sh_q <= full[BYTE_W-2:0];
              if (cnt_q == LAST_BIT) begin
                cnt_q <= '0;
                st_q  <= LK_ACKSET;
                case (st_q)
                  LK_ADDR: begin
                    if (ten_bit) begin
                      ack_q   <= hdr_ok;
                      after_q <= hdr_ok ? LK_ADDR2 : LK_SKIP;
                    end else begin
                      ack_q     <= a7_ok;
                      after_q   <= a7_ok ? LK_DATA : LK_SKIP;
                      addr_hit  <= a7_ok;
                      addressed <= a7_ok;
                    end
                  end
                  LK_ADDR2: begin
                    ack_q     <= lo_ok;
                    after_q   <= lo_ok ? LK_DATA : LK_SKIP;
                    addr_hit  <= lo_ok;
                    addressed <= lo_ok;
                  end
                  default: begin
                    ack_q     <= ack_en;
                    after_q   <= LK_DATA;
                    byte_done <= 1'b1;
                    byte_val  <= full;
                  end
                endcase
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          LK_ACKSET: begin
            if (scl_fall) begin
              sda_oe <= ack_q;
              st_q   <= LK_ACKEND;
            end
          end
          LK_ACKEND: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st_q   <= (after_q == LK_SKIP) ? LK_SKIP : LK_HOLD;
            end
          end
          LK_HOLD: begin
            if (!hold_req) st_q <= after_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe = (st_q == LK_HOLD) && hold_req;
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
  import i2c_srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              addr_hit,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              stop_hit,
  input  logic              bus_busy,
  input  logic              addressed,
  output logic              ack_en,
  output logic              ten_bit,
  output logic              addr_f,
  output logic              btf_f,
  output logic              stop_f,
  output logic              rxne_f,
  output logic              hold_req,
  output logic              irq_evt,
  output logic              irq_buf
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] pend_q;
  logic              armed_q;
  logic              rd_stat1, rd_stat2, rd_data, wr_ctrl;

  assign rd_stat1 = reg_rd && (reg_sel == SEL_STAT1);
  assign rd_stat2 = reg_rd && (reg_sel == SEL_STAT2);
  assign rd_data  = reg_rd && (reg_sel == SEL_DATA);
  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      addr_f  <= 1'b0;
      stop_f  <= 1'b0;
      btf_f   <= 1'b0;
      rxne_f  <= 1'b0;
      data_q  <= '0;
      pend_q  <= '0;
    end else begin
      if (rd_stat1)            armed_q <= 1'b1;
      else if (reg_rd || reg_wr) armed_q <= 1'b0;

      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);

      if (addr_hit)                  addr_f <= 1'b1;
      else if (rd_stat2 && armed_q)  addr_f <= 1'b0;

      if (stop_hit)                  stop_f <= 1'b1;
      else if (wr_ctrl && armed_q)   stop_f <= 1'b0;

      if (byte_done) begin
        if (!rxne_f || (rd_data && !btf_f)) begin
          data_q <= byte_val;
          rxne_f <= 1'b1;
        end else begin
          pend_q <= byte_val;
          btf_f  <= 1'b1;
        end
      end else if (rd_data) begin
        if (btf_f) begin
          if (armed_q) begin
            data_q <= pend_q;
            btf_f  <= 1'b0;
          end
        end else begin
          rxne_f <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL:  reg_rdata = ctrl_q;
      SEL_STAT1: reg_rdata = {4'b0, rxne_f, stop_f, btf_f, addr_f};
      SEL_STAT2: reg_rdata = {6'b0, addressed, bus_busy};
      default:   reg_rdata = data_q;
    endcase
  end

  assign ack_en   = ctrl_q.ack_en;
  assign ten_bit  = ctrl_q.ten_bit;
  assign hold_req = addr_f | btf_f;
  assign irq_evt  = ctrl_q.evt_ie & (addr_f | btf_f | stop_f);
  assign irq_buf  = ctrl_q.evt_ie & ctrl_q.buf_ie & rxne_f;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq_evt,
  output logic              irq_buf
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ack_en, ten_bit, hold_req;
  logic addr_hit, byte_done, stop_hit, bus_busy, addressed;
  logic addr_f, btf_f, stop_f, rxne_f;
  logic [BYTE_W-1:0] byte_val;

  i2c_srx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_srx_link link_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .ack_en(ack_en), .ten_bit(ten_bit), .own_addr(own_addr),
    .hold_req(hold_req), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .addr_hit(addr_hit), .byte_done(byte_done), .byte_val(byte_val),
    .stop_hit(stop_hit), .bus_busy(bus_busy), .addressed(addressed)
  );

  i2c_srx_regs regs_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .addr_hit(addr_hit), .byte_done(byte_done), .byte_val(byte_val),
    .stop_hit(stop_hit), .bus_busy(bus_busy), .addressed(addressed),
    .ack_en(ack_en), .ten_bit(ten_bit), .addr_f(addr_f), .btf_f(btf_f),
    .stop_f(stop_f), .rxne_f(rxne_f), .hold_req(hold_req),
    .irq_evt(irq_evt), .irq_buf(irq_buf)
  );
endmodule

// File: rtl/i2c_srx_chk.sv
module i2c_srx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic [1:0] reg_sel,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       addr_f,
  input logic       btf_f,
  input logic       stop_f,
  input logic       rxne_f,
  input logic       irq_buf
);
  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_hold_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (addr_f || btf_f));

  assert_addr_clear_by_stat2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_f) |-> $past(reg_rd && reg_sel == 2'd2));

  assert_btf_keeps_rxne_R6: assert property (@(posedge clk) disable iff (!rst_n)
    btf_f |-> rxne_f);

  assert_btf_clear_by_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(btf_f) |-> $past(reg_rd && reg_sel == 2'd3));

  assert_stop_clear_by_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_f) |-> $past(reg_wr && reg_sel == 2'd0));

  assert_buf_irq_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buf |-> rxne_f);
endmodule

bind i2c_slave_rx i2c_srx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .addr_f(addr_f),
  .btf_f(btf_f), .stop_f(stop_f), .rxne_f(rxne_f), .irq_buf(irq_buf)
);

// File: tb/i2c_slave_rx_tb.sv
module i2c_slave_rx_tb_top;
  localparam int HP = 6;
  localparam logic [9:0] OWN = 10'h25A;
  localparam logic [1:0] S_CTRL = 2'd0, S_ST1 = 2'd1, S_ST2 = 2'd2, S_DATA = 2'd3;
  localparam logic [7:0] C_ACK = 8'h01, C_EVT = 8'h02, C_BUF = 8'h04, C_TEN = 8'h08;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq_evt, irq_buf;
  logic [1:0] reg_sel = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_line, sda_line;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_slave_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .reg_sel(reg_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_evt(irq_evt), .irq_buf(irq_buf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0; tick(HP);
  endtask

  task automatic rep_start();
    m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; wait_high(); tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b1; wait_high(); tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(HP);
    m_scl = 1'b1; wait_high(); tick(HP);
    s = sda_line;
    m_scl = 1'b0; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] v, output int acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    acked = s ? 0 : 1;
    tick(2);
  endtask

  task automatic rd(input logic [1:0] s, output int d);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = int'(reg_rdata);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d, ack;
    logic s;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", {irq_evt, irq_buf}, 0);
    rd(S_CTRL, d); chk("R1 ctrl", d, 0);
    rd(S_ST1, d);  chk("R1 status1", d, 0);
    rd(S_ST2, d);  chk("R1 status2", d, 0);
    rd(S_DATA, d); chk("R1 data", d, 0);

    wr(S_CTRL, C_ACK | C_EVT | C_BUF);

    // R2 sweep of every 7-bit address with write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R2 address ack", ack, (a == int'(OWN[6:0])) ? 1 : 0);
      if (a == int'(OWN[6:0])) begin
        chk("R3 hold after match", scl_oe, 1);
        rd(S_ST1, d); chk("R2 address flag", d, 1);
        rd(S_ST2, d); tick(2);
        chk("R3 release", scl_oe, 0);
        bus_stop(); tick(4);
        rd(S_ST1, d); chk("R7 stop flag", d, 4);
        wr(S_CTRL, C_ACK | C_EVT | C_BUF);
      end else begin
        chk("R2 no hold", scl_oe, 0);
        bus_stop(); tick(4);
        rd(S_ST1, d); chk("R2 no flag", d, 0);
      end
    end
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);

    // R2 own address with read direction is refused
    bus_start();
    send_byte({OWN[6:0], 1'b1}, ack);
    chk("R2 read direction nack", ack, 0);
    bus_stop(); tick(4);
    rd(S_ST1, d); chk("R2 read direction flag", d, 0);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);

    // R3 clear ordering
    bus_start();
    send_byte({OWN[6:0], 1'b0}, ack);
    chk("R2 ack", ack, 1);
    rd(S_ST2, d); chk("R3 status2 addressed busy", d, 3);
    chk("R3 unarmed stays held", scl_oe, 1);
    chk("R8 evt irq on address", irq_evt, 1);
    rd(S_ST1, d); rd(S_DATA, d); rd(S_ST2, d); tick(2);
    chk("R3 broken pair stays held", scl_oe, 1);
    rd(S_ST1, d); rd(S_ST2, d); tick(2);
    chk("R3 ordered pair releases", scl_oe, 0);
    chk("R8 evt irq clears", irq_evt, 0);

    // R4 R5 data sweep
    for (int i = 0; i < 20; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 8'hFF);
      if (i == 16) v = 8'h00;
      if (i == 17) v = 8'hFF;
      if (i == 18) v = 8'h80;
      if (i == 19) v = 8'h01;
      send_byte(v, ack);
      chk("R5 data ack", ack, 1);
      chk("R8 buf irq", irq_buf, 1);
      rd(S_ST1, d); chk("R4 rxne set", d, 8);
      rd(S_DATA, d); chk("R4 data value", d, int'(v));
      rd(S_ST1, d); chk("R4 rxne cleared", d, 0);
    end

    // R5 acknowledge disabled
    wr(S_CTRL, C_EVT | C_BUF);
    send_byte(8'hC3, ack);
    chk("R5 nack when disabled", ack, 0);
    rd(S_DATA, d); chk("R5 byte still stored", d, 8'hC3);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);

    // R6 overrun
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    chk("R6 hold on overrun", scl_oe, 1);
    rd(S_ST1, d); chk("R6 flags", d, 8'h0A);
    rd(S_ST2, d);
    rd(S_DATA, d); tick(2);
    chk("R6 unarmed read no effect", scl_oe, 1);
    rd(S_ST1, d); chk("R6 flags kept", d, 8'h0A);
    rd(S_DATA, d); chk("R6 older byte", d, 8'h11);
    tick(2);
    chk("R6 release", scl_oe, 0);
    rd(S_ST1, d); chk("R6 rxne kept", d, 8);
    rd(S_DATA, d); chk("R6 pending byte", d, 8'h22);
    rd(S_ST1, d); chk("R6 empty", d, 0);

    // R7 stop clear ordering
    bus_stop(); tick(4);
    chk("R8 evt irq on stop", irq_evt, 1);
    rd(S_ST2, d); chk("R7 status2 idle", d, 0);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);
    chk("R7 unarmed write keeps flag", irq_evt, 1);
    rd(S_ST1, d); chk("R7 stop flag", d, 4);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);
    tick(1);
    chk("R7 cleared", irq_evt, 0);

    // R8 interrupt enable combinations
    bus_start();
    send_byte({OWN[6:0], 1'b0}, ack);
    rd(S_ST1, d); rd(S_ST2, d);
    send_byte(8'h77, ack);
    for (int e = 0; e < 4; e++) begin
      wr(S_CTRL, C_ACK | ((e & 1) != 0 ? C_EVT : 8'h00) | ((e & 2) != 0 ? C_BUF : 8'h00));
      tick(1);
      chk("R8 buf irq enables", irq_buf, (e == 3) ? 1 : 0);
    end
    wr(S_CTRL, C_ACK);
    bus_stop(); tick(4);
    chk("R8 evt irq masked", irq_evt, 0);
    rd(S_DATA, d); chk("R4 data", d, 8'h77);
    rd(S_ST1, d); chk("R7 stop flag masked irq", d, 4);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF | C_TEN);

    // R9 ten-bit addressing
    bus_start();
    send_byte({5'b11110, OWN[9:8], 1'b0}, ack);
    chk("R9 header ack", ack, 1);
    chk("R9 no hold after header", scl_oe, 0);
    rd(S_ST1, d); chk("R9 no flag after header", d, 0);
    send_byte(OWN[7:0], ack);
    chk("R9 low byte ack", ack, 1);
    rd(S_ST1, d); chk("R9 flag after low byte", d, 1);
    rd(S_ST2, d);
    send_byte(8'h3C, ack);
    rd(S_DATA, d); chk("R9 data", d, 8'h3C);
    bus_stop(); tick(4);
    rd(S_ST1, d); chk("R9 stop", d, 4);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF | C_TEN);

    bus_start();
    send_byte({5'b11110, ~OWN[9], OWN[8], 1'b0}, ack);
    chk("R9 wrong header nack", ack, 0);
    bus_stop(); tick(4);
    rd(S_ST1, d); chk("R9 wrong header flag", d, 0);

    bus_start();
    send_byte({5'b11110, OWN[9:8], 1'b0}, ack);
    send_byte(OWN[7:0] ^ 8'h01, ack);
    chk("R9 wrong low nack", ack, 0);
    bus_stop(); tick(4);
    rd(S_ST1, d); chk("R9 wrong low flag", d, 0);

    bus_start();
    send_byte({OWN[6:0], 1'b0}, ack);
    chk("R9 seven-bit form refused", ack, 0);
    bus_stop(); tick(4);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);

    // R10 repeated start inside a byte
    bus_start();
    send_byte({OWN[6:0], 1'b0}, ack);
    rd(S_ST1, d); rd(S_ST2, d);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    rep_start();
    send_byte({OWN[6:0], 1'b0}, ack);
    chk("R10 address after restart", ack, 1);
    rd(S_ST1, d); chk("R10 no partial byte", d, 1);
    rd(S_ST2, d);
    send_byte(8'h96, ack);
    rd(S_DATA, d); chk("R10 data after restart", d, 8'h96);
    bus_stop(); tick(4);
    rd(S_ST1, d); chk("R10 stop", d, 4);
    wr(S_CTRL, C_ACK | C_EVT | C_BUF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule